// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block scans a four-digit, common-strobe seven-segment display. It takes latched BCD digits, a sign bit and an overflow flag, and turns them into one set of shared segment lines plus one enable line per digit. One digit is lit at a time, and the digits take turns in a fixed order. Each digit gets a fixed time slot. The first part of every slot is dark, so that segment data never changes while a digit is lit.

The block adds two display rules. A zero in the leading digit is suppressed. When the overflow flag is set, the number is replaced by a fixed text: O, F and L on the three lower positions, with the leading position dark. A separate sign line carries the polarity of the reading at all times.

The block is meant to sit after a converter's output latch, clocked by the converter clock. The slot length and the dark gap are parameters. The defaults give 512 clocks per digit, with 16 of them dark.

Top module: `seg_scanner`

## Requirements
- R1: While reset is asserted, every digit enable, every segment line and the sign output are low, whatever the inputs are.
- R2: Digit enables are one-hot and active high. Each enable is held for 496 consecutive clocks. The enables step through bit 3 (most significant digit, `digits_i[15:12]`), then bit 2, bit 1 and bit 0 (`digits_i[3:0]`), and the order repeats.
- R3: Each 512-clock slot starts with 16 clocks in which all digit enables and all segment lines are low.
- R4: A digit code from 0 to 9 drives `seg_o` (bit 0 = a … bit 6 = g, active high) with the values 0→3F, 1→06, 2→5B, 3→4F, 4→66, 5→6D, 6→7D, 7→07, 8→7F, 9→6F (hex).
- R5: When the most significant digit code is 0, its slot shows no segments while its enable is still asserted. A zero in any lower position is shown as 3F.
- R6: Digit codes 10 to 15 show no segments in any position.
- R7: While the overflow input is high, the slot of bit 3 shows no segments, and bits 2, 1 and 0 show 3F (O), 71 (F) and 38 (L), whatever the digit inputs are.
- R8: `sign_o` equals `sign_i` delayed by one clock, including during the dark gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| digits_i | input | 16 | Four BCD codes, most significant digit in bits 15:12 |
| sign_i | input | 1 | Polarity of the reading |
| ovf_i | input | 1 | Overrange flag; selects the overflow text |
| seg_o | output | 7 | Segment lines, bit 0 = a to bit 6 = g, active high |
| dig_en_o | output | 4 | One-hot digit enables, bit 3 = most significant digit |
| sign_o | output | 1 | Registered sign line |

## Verification
The interesting overlap is leading-zero suppression and the overflow text, since both decide what the leading slot shows. The bench applies overflow once with a leading digit of 1 and once with a leading digit of 0. It expects a dark leading slot in both cases, and it expects the O/F/L text on the lower slots no matter what digits they hold. A third overlap, where a slot boundary coincides with new input values, is provoked by changing the inputs on the first dark clock after the least significant slot. The bench then judges the whole following scan against the new values.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_DARK  = 7'h00;
  localparam seg_t SEG_CHR_O = 7'h3F;
  localparam seg_t SEG_CHR_F = 7'h71;
  localparam seg_t SEG_CHR_L = 7'h38;

  // Segment order gfedcba, active high; codes above 9 stay dark.
  function automatic seg_t bcd_to_seg(input logic [3:0] code);
    seg_t s;
    case (code)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = SEG_DARK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int NUM_DIGITS = 4,
  parameter int SLOT_CLKS  = 512,
  parameter int BLANK_CLKS = 16,
  localparam int CNT_W = $clog2(SLOT_CLKS),
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] slot_idx_o,
  output logic             blank_o
);

  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SLOT_CLKS - 1);
  localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CLKS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             slot_end;

  always_comb begin
    slot_end = (cnt_q == LAST_CNT);
    cnt_d    = slot_end ? '0 : cnt_q + 1'b1;
    idx_d    = idx_q;
    if (slot_end) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign slot_idx_o = idx_q;
  assign blank_o    = (cnt_q < BLANK_END);

  // R2: leaving the last count of a slot moves to another digit
  p_slot_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST_CNT) |=> (idx_q != $past(idx_q)));

  // R3: the first count of a slot always lies in the dark gap
  p_gap_at_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST_CNT) |=> blank_o);

endmodule

// File: rtl/digit_select.sv
module digit_select
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int DIG_W = NUM_DIGITS * 4
) (
  input  logic [DIG_W-1:0] digits_i,
  input  logic [IDX_W-1:0] slot_idx_i,
  input  logic             ovf_i,
  output seg_t             seg_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  seg_t             ovf_pat [NUM_DIGITS];
  logic [IDX_W-1:0] pos;
  logic [3:0]       code;
  logic             lead_slot;

  // Overflow text on the three lowest positions, the rest dark.
  for (genvar p = 0; p < NUM_DIGITS; p++) begin : g_ovf_text
    if (p == 2) begin : g_o
      assign ovf_pat[p] = SEG_CHR_O;
    end else if (p == 1) begin : g_f
      assign ovf_pat[p] = SEG_CHR_F;
    end else if (p == 0) begin : g_l
      assign ovf_pat[p] = SEG_CHR_L;
    end else begin : g_dark
      assign ovf_pat[p] = SEG_DARK;
    end
  end

  always_comb begin
    pos       = LAST_IDX - slot_idx_i;
    code      = digits_i[{pos, 2'b00} +: 4];
    lead_slot = (slot_idx_i == '0);
    if (ovf_i) begin
      seg_o = ovf_pat[pos];
    end else if (lead_slot && code == 4'd0) begin
      seg_o = SEG_DARK;
    end else begin
      seg_o = bcd_to_seg(code);
    end
  end

endmodule

// File: rtl/enable_decode.sv
module enable_decode #(
  parameter int NUM_DIGITS = 4,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic [IDX_W-1:0]      slot_idx_i,
  input  logic                  active_i,
  output logic [NUM_DIGITS-1:0] en_o
);

  // Slot 0 lights the top enable bit, the last slot lights bit 0.
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_en
    assign en_o[g] = active_i && (slot_idx_i == IDX_W'(NUM_DIGITS - 1 - g));
  end

endmodule

// File: rtl/seg_scanner.sv
module seg_scanner
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int SLOT_CLKS  = 512,
  parameter int BLANK_CLKS = 16,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int DIG_W = NUM_DIGITS * 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIG_W-1:0]      digits_i,
  input  logic                  sign_i,
  input  logic                  ovf_i,
  output logic [SEG_W-1:0]      seg_o,
  output logic [NUM_DIGITS-1:0] dig_en_o,
  output logic                  sign_o
);

  logic [1:0]            rst_sync_q;
  logic                  rst_n_int;
  logic [IDX_W-1:0]      slot_idx;
  logic                  blank;
  seg_t                  seg_sel;
  logic [NUM_DIGITS-1:0] en_sel;

  seg_t                  seg_q, seg_d;
  logic [NUM_DIGITS-1:0] en_q, en_d;
  logic                  sign_q, sign_d;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  scan_timer #(
    .NUM_DIGITS(NUM_DIGITS),
    .SLOT_CLKS (SLOT_CLKS),
    .BLANK_CLKS(BLANK_CLKS)
  ) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .slot_idx_o(slot_idx),
    .blank_o   (blank)
  );

  digit_select #(
    .NUM_DIGITS(NUM_DIGITS)
  ) select_i (
    .digits_i  (digits_i),
    .slot_idx_i(slot_idx),
    .ovf_i     (ovf_i),
    .seg_o     (seg_sel)
  );

  enable_decode #(
    .NUM_DIGITS(NUM_DIGITS)
  ) enable_i (
    .slot_idx_i(slot_idx),
    .active_i  (!blank),
    .en_o      (en_sel)
  );

  always_comb begin
    seg_d  = blank ? SEG_DARK : seg_sel;
    en_d   = en_sel;
    sign_d = sign_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      seg_q  <= SEG_DARK;
      en_q   <= '0;
      sign_q <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      en_q   <= en_d;
      sign_q <= sign_d;
    end
  end

  assign seg_o    = seg_q;
  assign dig_en_o = en_q;
  assign sign_o   = sign_q;

  // R2: never two digits lit together
  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $onehot0(dig_en_o));

  // R8: sign follows its input one clock later
  p_sign_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    1'b1 |=> (sign_o == $past(sign_i)));

  // R7: overflow keeps the leading slot dark
  p_ovf_lead_dark_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($past(ovf_i) && dig_en_o[NUM_DIGITS-1]) |-> (seg_o == SEG_DARK));

  // R5: a zero leading digit shows no segments
  p_lead_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($past(digits_i[DIG_W-1 -: 4] == 4'd0) && dig_en_o[NUM_DIGITS-1])
      |-> (seg_o == SEG_DARK));

endmodule

// File: tb/seg_scanner_tb_top.sv
module seg_scanner_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 512;
  localparam int GAP        = 16;

  logic        clk;
  logic        rst_n;
  logic [15:0] digits;
  logic        sign_in;
  logic        ovf;
  logic [6:0]  seg;
  logic [3:0]  dig_en;
  logic        sign_out;

  int checks;
  int errors;
  bit done;

  typedef struct {
    logic [3:0] en;
    logic [6:0] seg;
    logic       sgn;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  seg_scanner dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .digits_i(digits),
    .sign_i  (sign_in),
    .ovf_i   (ovf),
    .seg_o   (seg),
    .dig_en_o(dig_en),
    .sign_o  (sign_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] model_seg(input int pos, input logic [3:0] code,
                                           input logic o);
    if (o) begin
      case (pos)
        2: return 7'h3F;
        1: return 7'h71;
        0: return 7'h38;
        default: return 7'h00;
      endcase
    end
    if (pos == 3 && code == 4'd0) return 7'h00;
    case (code)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // Driver: applies inputs at the start of the gap that follows the
  // least significant slot, then queues the next full scan.
  task automatic show(input logic [15:0] d, input logic s, input logic o,
                      input bit first, input string tag);
    if (!first) begin
      do @(negedge clk); while (dig_en !== 4'b0001);
      do @(negedge clk); while (dig_en !== 4'b0000);
    end
    digits  = d;
    sign_in = s;
    ovf     = o;
    for (int p = 3; p >= 0; p--) begin
      exp_t e;
      e.en  = 4'(1 << p);
      e.seg = model_seg(p, d[p*4 +: 4], o);
      e.sgn = s;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // Monitor: compares each slot start against the queue and measures runs.
  initial begin
    logic [3:0] prev_en;
    int         off_run;
    int         on_run;
    bit         seen_slot;
    bit         gap_lit;
    prev_en   = '0;
    off_run   = 0;
    on_run    = 0;
    seen_slot = 0;
    gap_lit   = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_en = '0;
        off_run = 0;
        continue;
      end
      if (dig_en == 4'b0000) begin
        if (prev_en != 4'b0000 && seen_slot)
          check(on_run == SLOT - GAP, "R2 enable run length", on_run, SLOT - GAP);
        if (seg != 7'h00) gap_lit = 1;
        off_run++;
        on_run = 0;
      end else begin
        if (prev_en == 4'b0000) begin
          if (seen_slot) begin
            check(off_run == GAP, "R3 dark gap length", off_run, GAP);
            check(!gap_lit, "R3 segments dark in gap", {31'd0, gap_lit}, 0);
          end
          if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(dig_en == e.en, "R2 enable order", dig_en, e.en);
            check(seg == e.seg, e.tag, seg, e.seg);
            check(sign_out == e.sgn, "R8 sign output", sign_out, e.sgn);
          end
          seen_slot = 1;
          gap_lit   = 0;
          off_run   = 0;
        end else if (prev_en != dig_en) begin
          check(0, "R2 enable changed without gap", dig_en, prev_en);
        end
        on_run++;
      end
      prev_en = dig_en;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 0;
    rst_n   = 1'b0;
    digits  = 16'h8888;
    sign_in = 1'b1;
    ovf     = 1'b1;
    repeat (5) @(negedge clk);
    check(dig_en == 4'b0000, "R1 reset enables", dig_en, 0);
    check(seg == 7'h00, "R1 reset segments", seg, 0);
    check(sign_out == 1'b0, "R1 reset sign", sign_out, 0);

    show(16'h1234, 1'b0, 1'b0, 1, "R4 digits 1234");
    @(negedge clk);
    rst_n = 1'b1;
    show(16'h0567, 1'b1, 1'b0, 0, "R5 leading zero blanked");
    show(16'h0000, 1'b0, 1'b0, 0, "R5 lower zeros shown");
    show(16'h9809, 1'b1, 1'b0, 0, "R4 digits 9809");
    show(16'hCAF3, 1'b0, 1'b0, 0, "R6 codes above 9 dark");
    show(16'h1399, 1'b1, 1'b1, 0, "R7 overflow over nonzero lead");
    show(16'h0000, 1'b0, 1'b1, 0, "R7 overflow over zero lead");
    show(16'h1675, 1'b0, 1'b0, 0, "R4 digits 1675");

    while (exp_q.size() > 0) @(negedge clk);
    do @(negedge clk); while (dig_en !== 4'b0000);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule